// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic unit that sits beside an 8-bit accumulator. Each cycle in which `opValid` is high it takes an operation code, the accumulator value, a second operand and the current carry, auxiliary-carry and overflow flags. One clock later it presents a result byte, a high byte used only by multiply and divide, and the three flags, each flag with its own write enable. The instruction decoder supplies the operation and the operands. The register file commits the result and whichever flags are enabled.

The second operand is the B register value or an immediate byte, chosen by `useImm`. Multiply and divide always use the B register input. Decoding, operand fetch and register storage sit outside the block. Within the block, a decode stage turns the operation code into a small set of strobes, and a registered datapath acts on those strobes.

Top module: `acc_alu`

## Requirements
- R1: Operation codes on `opSel` are 0 ADD, 1 ADDC, 2 SUBB, 3 INC, 4 DEC, 5 MUL, 6 DIV, 7 DA, 8 AND, 9 OR, 10 XOR, 11 CPL, 12 CLR, 13 RL, 14 RLC, 15 RR, 16 RRC, 17 SWAP. Any other code returns the accumulator unchanged and writes no flag. Results appear on the cycle after `opValid` is sampled high, and `resValid` is high in exactly that cycle.
- R2: ADD gives A+op and ADDC gives A+op+C. C is the carry out of bit 7, AC is the carry out of bit 3, and OV is the carry out of bit 7 XOR the carry into bit 7. All three flag enables are high.
- R3: SUBB gives A−op−C. C is the borrow out of bit 7, AC is the borrow out of bit 3, and OV flags signed overflow. All three flag enables are high.
- R4: INC and DEC add or subtract one from A, wrapping modulo 256. No flag is written.
- R5: MUL puts the 16-bit product A×B on `resHi`:`resLo` (FFh×FFh gives FE01h). OV is set when the product exceeds FFh, C is cleared, and the enables for the high byte, C and OV are high.
- R6: DIV puts A/B on `resLo` and A mod B on `resHi`, and clears C and OV. When B is zero, OV is set, C is cleared and both data bytes are unspecified.
- R7: DA adds 06h when the low nibble exceeds 9 or AC is set. It then adds 60h when the high nibble exceeds 9, C is set or the first step carried. C becomes the old C OR any carry out of those steps, and only C is written (4Ch gives 52h).
- R8: AND, OR, XOR, CPL (invert A) and CLR (zero) write no flag.
- R9: RL and RR rotate A by one place without involving C, and SWAP exchanges the nibbles of A. No flag is written.
- R10: RLC and RRC rotate through carry: the bit shifted out goes to C and the old C fills the vacated bit. Only C is written.
- R11: When `useImm` is high, ADD, ADDC, SUBB, AND, OR and XOR take `immIn` as the operand in place of `bIn`. MUL and DIV always use `bIn`.
- R12: Each flag output whose enable is low equals that flag's input from the issuing cycle. `hiWe` is high only for MUL and DIV.
- R13: During reset, `resValid`, the data outputs, the flags and every write enable are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| opValid | input | 1 | Operation issued this cycle |
| opSel | input | 5 | Operation code |
| useImm | input | 1 | Select immediate byte as operand |
| accIn | input | 8 | Accumulator value |
| bIn | input | 8 | B register value |
| immIn | input | 8 | Immediate byte |
| cIn | input | 1 | Current carry flag |
| acIn | input | 1 | Current auxiliary carry flag |
| ovIn | input | 1 | Current overflow flag |
| resValid | output | 1 | Result valid |
| resLo | output | 8 | Result byte for the accumulator |
| resHi | output | 8 | High byte for B (MUL, DIV) |
| hiWe | output | 1 | Write enable for the high byte |
| cOut | output | 1 | Carry flag value |
| acOut | output | 1 | Auxiliary carry flag value |
| ovOut | output | 1 | Overflow flag value |
| cWe | output | 1 | Carry flag write enable |
| acWe | output | 1 | Auxiliary carry write enable |
| ovWe | output | 1 | Overflow write enable |

## Verification
The bench builds the block with the default width of eight bits. At that width, every flag boundary can be reached directly with a handful of hand-chosen operands: the carry into and out of the sign bit, the borrow out of the low nibble, and the nibble thresholds of the decimal correction. The chosen operands include the largest product, a division with a zero quotient, division by zero, and decimal corrections that wrap to zero.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_INC  = 5'd3,
    OP_DEC  = 5'd4,
    OP_MUL  = 5'd5,
    OP_DIV  = 5'd6,
    OP_DA   = 5'd7,
    OP_AND  = 5'd8,
    OP_OR   = 5'd9,
    OP_XOR  = 5'd10,
    OP_CPL  = 5'd11,
    OP_CLR  = 5'd12,
    OP_RL   = 5'd13,
    OP_RLC  = 5'd14,
    OP_RR   = 5'd15,
    OP_RRC  = 5'd16,
    OP_SWAP = 5'd17
  } aluOp_e;

  typedef enum logic [3:0] {
    U_PASS, U_ADD, U_SUB, U_STEP, U_MUL, U_DIV, U_DA, U_BIT, U_ROT
  } unit_e;

  typedef enum logic [2:0] {
    BIT_AND, BIT_OR, BIT_XOR, BIT_CPL, BIT_CLR
  } bitOp_e;

  typedef enum logic [2:0] {
    ROT_L, ROT_LC, ROT_R, ROT_RC, ROT_SWAP
  } rotOp_e;

  // Strobes handed from the decode stage to the datapath
  typedef struct packed {
    unit_e  unit;
    logic   useCarry;
    logic   stepDown;
    logic   useImm;
    bitOp_e bitOp;
    rotOp_e rotOp;
    logic   wrHi;
    logic   wrC;
    logic   wrAc;
    logic   wrOv;
  } aluCtl_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
`timescale 1ns/1ps
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  input  logic            useImm,
  output aluCtl_t         ctl
);

  always_comb begin
    ctl = '{unit: U_PASS, useCarry: 1'b0, stepDown: 1'b0, useImm: 1'b0,
            bitOp: BIT_AND, rotOp: ROT_L, wrHi: 1'b0, wrC: 1'b0,
            wrAc: 1'b0, wrOv: 1'b0};
    case (aluOp_e'(opSel))
      OP_ADD, OP_ADDC: begin
        ctl.unit     = U_ADD;
        ctl.useCarry = (aluOp_e'(opSel) == OP_ADDC);
        ctl.useImm   = useImm;
        ctl.wrC      = 1'b1;
        ctl.wrAc     = 1'b1;
        ctl.wrOv     = 1'b1;
      end
      OP_SUBB: begin
        ctl.unit     = U_SUB;
        ctl.useCarry = 1'b1;
        ctl.useImm   = useImm;
        ctl.wrC      = 1'b1;
        ctl.wrAc     = 1'b1;
        ctl.wrOv     = 1'b1;
      end
      OP_INC: ctl.unit = U_STEP;
      OP_DEC: begin
        ctl.unit     = U_STEP;
        ctl.stepDown = 1'b1;
      end
      OP_MUL, OP_DIV: begin
        ctl.unit = (aluOp_e'(opSel) == OP_MUL) ? U_MUL : U_DIV;
        ctl.wrHi = 1'b1;
        ctl.wrC  = 1'b1;
        ctl.wrOv = 1'b1;
      end
      OP_DA: begin
        ctl.unit = U_DA;
        ctl.wrC  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        ctl.unit   = U_BIT;
        ctl.useImm = useImm;
        ctl.bitOp  = (aluOp_e'(opSel) == OP_AND) ? BIT_AND :
                     (aluOp_e'(opSel) == OP_OR)  ? BIT_OR  : BIT_XOR;
      end
      OP_CPL: begin
        ctl.unit  = U_BIT;
        ctl.bitOp = BIT_CPL;
      end
      OP_CLR: begin
        ctl.unit  = U_BIT;
        ctl.bitOp = BIT_CLR;
      end
      OP_RL: begin
        ctl.unit  = U_ROT;
        ctl.rotOp = ROT_L;
      end
      OP_RR: begin
        ctl.unit  = U_ROT;
        ctl.rotOp = ROT_R;
      end
      OP_SWAP: begin
        ctl.unit  = U_ROT;
        ctl.rotOp = ROT_SWAP;
      end
      OP_RLC: begin
        ctl.unit  = U_ROT;
        ctl.rotOp = ROT_LC;
        ctl.wrC   = 1'b1;
      end
      OP_RRC: begin
        ctl.unit  = U_ROT;
        ctl.rotOp = ROT_RC;
        ctl.wrC   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu_dp.sv
`timescale 1ns/1ps
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  aluCtl_t           ctl,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic [DATA_W-1:0] immIn,
  input  logic              cIn,
  input  logic              acIn,
  input  logic              ovIn,
  output logic              resValid,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi,
  output logic              hiWe,
  output logic              cOut,
  output logic              acOut,
  output logic              ovOut,
  output logic              cWe,
  output logic              acWe,
  output logic              ovWe
);

  localparam int NIB    = DATA_W / 2;
  localparam int PROD_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ONE_W  = DATA_W'(1);
  localparam logic [DATA_W:0]   SIX_LO = (DATA_W+1)'(6);
  localparam logic [DATA_W:0]   SIX_HI = SIX_LO << NIB;
  localparam logic [NIB-1:0]    BCD_MAX = NIB'(9);

  logic [DATA_W-1:0] operand;
  logic              cUse;

  // adder / subtractor
  logic [DATA_W:0]   sumFull, diffFull;
  logic [NIB:0]      lowSum, lowDiff;
  logic [DATA_W-1:0] belowMsbSum;
  // multiply / divide
  logic [PROD_W-1:0] prod;
  logic              divZero;
  logic [DATA_W-1:0] quot, rem;
  // decimal correction
  logic              lowFix, highFix;
  logic [DATA_W:0]   daStep1, daStep2;
  // rotate / bitwise
  logic [DATA_W-1:0] rotRes, bitRes;
  logic              rotC;

  logic [DATA_W-1:0] loNext, hiNext;
  logic              cCalc, acCalc, ovCalc;

  assign operand = ctl.useImm ? immIn : bIn;
  assign cUse    = ctl.useCarry & cIn;

  always_comb begin
    sumFull     = {1'b0, accIn} + {1'b0, operand} + {{DATA_W{1'b0}}, cUse};
    lowSum      = {1'b0, accIn[NIB-1:0]} + {1'b0, operand[NIB-1:0]} + {{NIB{1'b0}}, cUse};
    belowMsbSum = {1'b0, accIn[DATA_W-2:0]} + {1'b0, operand[DATA_W-2:0]}
                + {{(DATA_W-1){1'b0}}, cUse};
    diffFull    = {1'b0, accIn} - {1'b0, operand} - {{DATA_W{1'b0}}, cUse};
    lowDiff     = {1'b0, accIn[NIB-1:0]} - {1'b0, operand[NIB-1:0]} - {{NIB{1'b0}}, cUse};
  end

  always_comb begin
    prod    = {{DATA_W{1'b0}}, accIn} * {{DATA_W{1'b0}}, bIn};
    divZero = (bIn == '0);
    quot    = divZero ? '0 : accIn / bIn;
    rem     = divZero ? '0 : accIn % bIn;
  end

  always_comb begin
    lowFix  = (accIn[NIB-1:0] > BCD_MAX) || acIn;
    daStep1 = {1'b0, accIn} + (lowFix ? SIX_LO : '0);
    highFix = (daStep1[DATA_W-1:NIB] > BCD_MAX) || cIn || daStep1[DATA_W];
    daStep2 = {1'b0, daStep1[DATA_W-1:0]} + (highFix ? SIX_HI : '0);
  end

  always_comb begin
    rotC = cIn;
    case (ctl.rotOp)
      ROT_L:  rotRes = {accIn[DATA_W-2:0], accIn[DATA_W-1]};
      ROT_LC: begin
        rotRes = {accIn[DATA_W-2:0], cIn};
        rotC   = accIn[DATA_W-1];
      end
      ROT_R:  rotRes = {accIn[0], accIn[DATA_W-1:1]};
      ROT_RC: begin
        rotRes = {cIn, accIn[DATA_W-1:1]};
        rotC   = accIn[0];
      end
      default: rotRes = {accIn[NIB-1:0], accIn[DATA_W-1:NIB]};
    endcase
  end

  always_comb begin
    case (ctl.bitOp)
      BIT_AND: bitRes = accIn & operand;
      BIT_OR:  bitRes = accIn | operand;
      BIT_XOR: bitRes = accIn ^ operand;
      BIT_CPL: bitRes = ~accIn;
      default: bitRes = '0;
    endcase
  end

  always_comb begin
    loNext = accIn;
    hiNext = '0;
    cCalc  = cIn;
    acCalc = acIn;
    ovCalc = ovIn;
    case (ctl.unit)
      U_ADD: begin
        loNext = sumFull[DATA_W-1:0];
        cCalc  = sumFull[DATA_W];
        acCalc = lowSum[NIB];
        ovCalc = sumFull[DATA_W] ^ belowMsbSum[DATA_W-1];
      end
      U_SUB: begin
        loNext = diffFull[DATA_W-1:0];
        cCalc  = diffFull[DATA_W];
        acCalc = lowDiff[NIB];
        ovCalc = (accIn[DATA_W-1] != operand[DATA_W-1]) &&
                 (diffFull[DATA_W-1] != accIn[DATA_W-1]);
      end
      U_STEP: loNext = ctl.stepDown ? accIn - ONE_W : accIn + ONE_W;
      U_MUL: begin
        loNext = prod[DATA_W-1:0];
        hiNext = prod[PROD_W-1:DATA_W];
        cCalc  = 1'b0;
        ovCalc = |prod[PROD_W-1:DATA_W];
      end
      U_DIV: begin
        loNext = quot;
        hiNext = rem;
        cCalc  = 1'b0;
        ovCalc = divZero;
      end
      U_DA: begin
        loNext = daStep2[DATA_W-1:0];
        cCalc  = cIn | daStep1[DATA_W] | daStep2[DATA_W];
      end
      U_BIT: loNext = bitRes;
      U_ROT: begin
        loNext = rotRes;
        cCalc  = rotC;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resLo    <= '0;
      resHi    <= '0;
      hiWe     <= 1'b0;
      cOut     <= 1'b0;
      acOut    <= 1'b0;
      ovOut    <= 1'b0;
      cWe      <= 1'b0;
      acWe     <= 1'b0;
      ovWe     <= 1'b0;
    end else begin
      resValid <= opValid;
      if (opValid) begin
        resLo <= loNext;
        resHi <= hiNext;
        hiWe  <= ctl.wrHi;
        cOut  <= ctl.wrC  ? cCalc  : cIn;
        acOut <= ctl.wrAc ? acCalc : acIn;
        ovOut <= ctl.wrOv ? ovCalc : ovIn;
        cWe   <= ctl.wrC;
        acWe  <= ctl.wrAc;
        ovWe  <= ctl.wrOv;
      end
    end
  end

  // R1
  result_follows_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);

  // R5
  mul_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid && $past(ctl.unit == U_MUL) |-> (ovOut == (resHi != '0)) && !cOut);

  // R6
  div_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid && $past(ctl.unit == U_DIV) |-> !cOut && (ovOut == ($past(bIn) == '0)));

  // R4
  step_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid && $past(ctl.unit == U_STEP) |-> !cWe && !acWe && !ovWe);

  // R12
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !cWe |-> cOut == $past(cIn));

  // R12
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !acWe |-> acOut == $past(acIn));

  // R12
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !ovWe |-> ovOut == $past(ovIn));

  // R12
  high_byte_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid && hiWe |-> $past(ctl.unit == U_MUL || ctl.unit == U_DIV));

endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opSel,
  input  logic              useImm,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic [DATA_W-1:0] immIn,
  input  logic              cIn,
  input  logic              acIn,
  input  logic              ovIn,
  output logic              resValid,
  output logic [DATA_W-1:0] resLo,
  output logic [DATA_W-1:0] resHi,
  output logic              hiWe,
  output logic              cOut,
  output logic              acOut,
  output logic              ovOut,
  output logic              cWe,
  output logic              acWe,
  output logic              ovWe
);

  aluCtl_t ctl;

  acc_alu_ctrl u_ctrl (
    .opSel  (opSel),
    .useImm (useImm),
    .ctl    (ctl)
  );

  acc_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .ctl      (ctl),
    .accIn    (accIn),
    .bIn      (bIn),
    .immIn    (immIn),
    .cIn      (cIn),
    .acIn     (acIn),
    .ovIn     (ovIn),
    .resValid (resValid),
    .resLo    (resLo),
    .resHi    (resHi),
    .hiWe     (hiWe),
    .cOut     (cOut),
    .acOut    (acOut),
    .ovOut    (ovOut),
    .cWe      (cWe),
    .acWe     (acWe),
    .ovWe     (ovWe)
  );

endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;

  localparam int W  = 8;
  localparam int NV = 32;
  localparam int WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic [4:0]   opSel = '0;
  logic         useImm = 1'b0;
  logic [W-1:0] accIn = '0, bIn = '0, immIn = '0;
  logic         cIn = 1'b0, acIn = 1'b0, ovIn = 1'b0;
  logic         resValid, hiWe, cOut, acOut, ovOut, cWe, acWe, ovWe;
  logic [W-1:0] resLo, resHi;

  int nChecks = 0;
  int nFail   = 0;

  always #2.5 clk = ~clk;

  acc_alu #(.DATA_W(W)) uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .useImm(useImm),
    .accIn(accIn), .bIn(bIn), .immIn(immIn), .cIn(cIn), .acIn(acIn), .ovIn(ovIn),
    .resValid(resValid), .resLo(resLo), .resHi(resHi), .hiWe(hiWe),
    .cOut(cOut), .acOut(acOut), .ovOut(ovOut), .cWe(cWe), .acWe(acWe), .ovWe(ovWe)
  );

  // {op, a, b, flagsIn(c,ac,ov), expLo, expHi, expFlags(c,ac,ov), expWe(hi,c,ac,ov)}
  localparam logic [46:0] VEC [NV] = '{
    {5'd0,  8'h3F, 8'hD3, 3'b000, 8'h12, 8'h00, 3'b110, 4'b0111}, // R2
    {5'd0,  8'h7F, 8'h73, 3'b100, 8'hF2, 8'h00, 3'b011, 4'b0111}, // R2 carry ignored
    {5'd1,  8'h8F, 8'hD3, 3'b100, 8'h63, 8'h00, 3'b111, 4'b0111}, // R2
    {5'd1,  8'hFF, 8'h00, 3'b100, 8'h00, 8'h00, 3'b110, 4'b0111}, // R2
    {5'd2,  8'h50, 8'h20, 3'b100, 8'h2F, 8'h00, 3'b010, 4'b0111}, // R3
    {5'd2,  8'h10, 8'h20, 3'b000, 8'hF0, 8'h00, 3'b100, 4'b0111}, // R3
    {5'd2,  8'h80, 8'h01, 3'b000, 8'h7F, 8'h00, 3'b011, 4'b0111}, // R3
    {5'd2,  8'h7F, 8'hFF, 3'b000, 8'h80, 8'h00, 3'b101, 4'b0111}, // R3
    {5'd3,  8'hFF, 8'h00, 3'b110, 8'h00, 8'h00, 3'b110, 4'b0000}, // R4 R12
    {5'd4,  8'h00, 8'h00, 3'b010, 8'hFF, 8'h00, 3'b010, 4'b0000}, // R4 R12
    {5'd5,  8'hFF, 8'hFF, 3'b110, 8'h01, 8'hFE, 3'b011, 4'b1101}, // R5
    {5'd5,  8'h12, 8'h05, 3'b111, 8'h5A, 8'h00, 3'b010, 4'b1101}, // R5
    {5'd6,  8'h64, 8'h07, 3'b101, 8'h0E, 8'h02, 3'b000, 4'b1101}, // R6
    {5'd6,  8'h05, 8'h09, 3'b111, 8'h00, 8'h05, 3'b010, 4'b1101}, // R6
    {5'd7,  8'h4C, 8'h00, 3'b000, 8'h52, 8'h00, 3'b000, 4'b0100}, // R7
    {5'd7,  8'h9A, 8'h00, 3'b000, 8'h00, 8'h00, 3'b100, 4'b0100}, // R7
    {5'd7,  8'h12, 8'h00, 3'b010, 8'h18, 8'h00, 3'b010, 4'b0100}, // R7
    {5'd7,  8'h20, 8'h00, 3'b100, 8'h80, 8'h00, 3'b100, 4'b0100}, // R7
    {5'd7,  8'h9C, 8'h00, 3'b000, 8'h02, 8'h00, 3'b100, 4'b0100}, // R7
    {5'd8,  8'hF0, 8'h3C, 3'b111, 8'h30, 8'h00, 3'b111, 4'b0000}, // R8
    {5'd9,  8'h0F, 8'hA0, 3'b000, 8'hAF, 8'h00, 3'b000, 4'b0000}, // R8
    {5'd10, 8'hFF, 8'h5A, 3'b101, 8'hA5, 8'h00, 3'b101, 4'b0000}, // R8
    {5'd11, 8'h5A, 8'h00, 3'b010, 8'hA5, 8'h00, 3'b010, 4'b0000}, // R8
    {5'd12, 8'h77, 8'h00, 3'b111, 8'h00, 8'h00, 3'b111, 4'b0000}, // R8
    {5'd13, 8'h81, 8'h00, 3'b000, 8'h03, 8'h00, 3'b000, 4'b0000}, // R9
    {5'd14, 8'h81, 8'h00, 3'b000, 8'h02, 8'h00, 3'b100, 4'b0100}, // R10
    {5'd14, 8'h3C, 8'h00, 3'b111, 8'h79, 8'h00, 3'b011, 4'b0100}, // R10
    {5'd15, 8'h81, 8'h00, 3'b000, 8'hC0, 8'h00, 3'b000, 4'b0000}, // R9
    {5'd16, 8'h81, 8'h00, 3'b000, 8'h40, 8'h00, 3'b100, 4'b0100}, // R10
    {5'd16, 8'hBD, 8'h00, 3'b001, 8'h5E, 8'h00, 3'b101, 4'b0100}, // R10
    {5'd17, 8'h72, 8'h00, 3'b110, 8'h27, 8'h00, 3'b110, 4'b0000}, // R9
    {5'd31, 8'h55, 8'h00, 3'b101, 8'h55, 8'h00, 3'b101, 4'b0000}  // R1 unused code
  };

  function automatic string reqOf(input logic [4:0] op);
    case (op)
      5'd0, 5'd1:                      return "R2";
      5'd2:                            return "R3";
      5'd3, 5'd4:                      return "R4";
      5'd5:                            return "R5";
      5'd6:                            return "R6";
      5'd7:                            return "R7";
      5'd8, 5'd9, 5'd10, 5'd11, 5'd12: return "R8";
      5'd13, 5'd15, 5'd17:             return "R9";
      5'd14, 5'd16:                    return "R10";
      default:                         return "R1";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic immEn, input logic [W-1:0] imm, input logic [2:0] fin);
    @(negedge clk);
    opSel   = op;
    accIn   = a;
    bIn     = b;
    useImm  = immEn;
    immIn   = imm;
    {cIn, acIn, ovIn} = fin;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    // R13 reset state
    repeat (3) @(negedge clk);
    chk("R13", "reset outputs",
        {resValid, resLo, resHi, hiWe, cOut, acOut, ovOut, cWe, acWe, ovWe}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "idle resValid", resValid, 1'b0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      logic [W-1:0] hiAct;
      v = VEC[i];
      issue(v[46:42], v[41:34], v[33:26], 1'b0, ~v[33:26], v[25:23]);
      hiAct = hiWe ? resHi : 8'h00;
      chk("R1", "resValid", resValid, 1'b1);
      chk(reqOf(v[46:42]), $sformatf("vector %0d", i),
          {resLo, hiAct, cOut, acOut, ovOut, hiWe, cWe, acWe, ovWe}, v[22:0]);
    end

    // R1 resValid drops when nothing is issued
    @(negedge clk);
    chk("R1", "resValid after idle", resValid, 1'b0);

    // R11 immediate operand for add, and: B input ignored
    issue(5'd0, 8'h10, 8'hFF, 1'b1, 8'h05, 3'b000);
    chk("R11", "add imm", {resLo, cOut, acOut, ovOut}, {8'h15, 3'b000});
    issue(5'd8, 8'hFF, 8'h00, 1'b1, 8'h3C, 3'b000);
    chk("R11", "and imm", resLo, 8'h3C);
    issue(5'd2, 8'h09, 8'h00, 1'b1, 8'h0A, 3'b000);
    chk("R11", "subb imm", {resLo, cOut, acOut, ovOut}, {8'hFF, 3'b110});
    // R11 multiply keeps B even with immediate selected
    issue(5'd5, 8'h03, 8'h04, 1'b1, 8'h10, 3'b000);
    chk("R11", "mul ignores imm", {resHi, resLo}, 16'h000C);

    // R6 divide by zero: flags only
    issue(5'd6, 8'h37, 8'h00, 1'b0, 8'h00, 3'b110);
    chk("R6", "div by zero flags", {cOut, acOut, ovOut, hiWe, cWe, ovWe}, 6'b011111);

    // R12 pass-through with a different flag pattern, back-to-back issue
    issue(5'd13, 8'h01, 8'h00, 1'b0, 8'h00, 3'b101);
    chk("R12", "rl pass flags", {resLo, cOut, acOut, ovOut, cWe, acWe, ovWe},
        {8'h02, 3'b101, 3'b000});

    // R13 reset again mid-run clears outputs
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R13", "second reset", {resValid, resLo, cOut, ovOut}, 32'h0);
    rstN = 1'b1;

    repeat (2) @(negedge clk);
    finish();
  end

endmodule